// File: doc/BRIEF.md
# SPI NOR Flash Operation Sequencer

This block drives a single-I/O serial NOR flash in SPI mode 0 and turns four host requests into complete flash command sequences: read one page, program one page, erase the whole chip, and read the status byte. The host hands over a request code and a 16-bit page number. The block expands the page number into a 24-bit byte address, inserts a write-enable frame before any operation that alters the array, and frames every command with its own chip-select low period.

Page data moves as a byte stream. For a program request the block pulls one byte per `wr_taken` pulse. For a read request it pushes one byte per `rd_valid` pulse. After a program or erase it keeps sending status-read frames until the busy bit clears. If the busy bit stays set after a parameter-set number of polls, it gives up and reports a timeout. Bytes the device returns in frames that carry no data for the host are discarded.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, `spi_cs_n` is high, `spi_sck` is low and `req_ready` is high. `spi_sck` never goes high while `spi_cs_n` is high.
- R2: Every falling edge of `spi_cs_n`, including the first one after reset, comes after `spi_cs_n` has been high for at least 2*CLK_DIV clock cycles.
- R3: Bus timing follows mode 0:
  - `spi_sck` is low whenever `spi_cs_n` changes.
  - Each byte is eight `spi_sck` pulses with the most significant bit first.
  - `spi_mosi` does not change while `spi_sck` is high.
  - `spi_miso` is sampled on the rising edge.
  - Every frame holds a whole number of bytes.
- R4: A page read (`req_op` = 0) is one frame that sends 0x03, then the page number high byte, the page number low byte and 0x00. It then returns the 256 bytes of that page in address order, one per `rd_valid` pulse.
- R5: A page program (`req_op` = 1) sends a one-byte frame 0x06. It then sends a frame of 0x02, the three address bytes formed as in R4, and 256 data bytes taken from `wr_data`, one per `wr_taken` pulse.
- R6: A chip erase (`req_op` = 2) sends a one-byte frame 0x06, followed by a separate one-byte frame 0xC7.
- R7: After the program or erase frame, the block sends two-byte frames starting with 0x05. It reports `op_done` without `op_timeout` only after a poll returns bit 0 = 0.
- R8: If POLL_LIMIT consecutive polls all return bit 0 = 1, the block stops polling and pulses `op_done` together with `op_timeout`.
- R9: A status request (`req_op` = 3) is a single two-byte frame starting with 0x05. Its second received byte is delivered by one `rd_valid` pulse, and no polling follows.
- R10: Received bytes are ignored and raise no `rd_valid` in these frames and byte positions:
  - write-enable frames
  - program frames
  - erase frames
  - poll frames
  - the opcode and address bytes of a read
- R11: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the operation ends. At that point `op_done` pulses exactly once, in a cycle where `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | 0 read page, 1 program page, 2 erase chip, 3 read status |
| req_page | input | 16 | Page number for read and program |
| req_ready | output | 1 | Block idle and able to take a request |
| wr_data | input | 8 | Next byte to program |
| wr_taken | output | 1 | Pulse: `wr_data` was consumed, present the next byte |
| rd_data | output | 8 | Byte read from the page or status register |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| op_done | output | 1 | Pulse: operation finished |
| op_timeout | output | 1 | Pulse with `op_done`: busy polling gave up |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV = 2 and POLL_LIMIT = 4. This keeps a full 260-byte page frame to a few thousand cycles, so read and program of complete pages fit in one run. A device that stays busy for 100 polls runs into the timeout after four polls rather than after a long wait. The bench's flash model reports three or one busy polls before going idle, which exercises both a multi-poll wait and the shortest one. It returns 0xA5 in every byte position whose data must be ignored.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

  localparam int PAGE_LO_W  = 8;
  localparam int PAGE_BYTES = 1 << PAGE_LO_W;
  localparam int HDR_BYTES  = 4;
  localparam int IDX_W      = $clog2(PAGE_BYTES + HDR_BYTES + 1);

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ERASE = 8'hC7;
  localparam logic [7:0] OPC_STAT  = 8'h05;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_STAT  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    FK_WREN,
    FK_READ,
    FK_PROG,
    FK_ERASE,
    FK_STAT,
    FK_POLL
  } frame_e;

  function automatic logic [23:0] page_addr(input logic [15:0] page);
    return {page, 8'h00};
  endfunction

  function automatic frame_e main_frame(input op_e op);
    case (op)
      OP_READ:  return FK_READ;
      OP_PROG:  return FK_PROG;
      OP_ERASE: return FK_ERASE;
      default:  return FK_STAT;
    endcase
  endfunction

  function automatic frame_e first_frame(input op_e op);
    if (op == OP_PROG || op == OP_ERASE) return FK_WREN;
    return main_frame(op);
  endfunction

  function automatic logic [IDX_W-1:0] frame_len(input frame_e k);
    case (k)
      FK_READ, FK_PROG: return IDX_W'(HDR_BYTES + PAGE_BYTES);
      FK_STAT, FK_POLL: return IDX_W'(2);
      default:          return IDX_W'(1);
    endcase
  endfunction

  function automatic logic [7:0] frame_opcode(input frame_e k);
    case (k)
      FK_WREN:  return OPC_WREN;
      FK_READ:  return OPC_READ;
      FK_PROG:  return OPC_PROG;
      FK_ERASE: return OPC_ERASE;
      default:  return OPC_STAT;
    endcase
  endfunction

  function automatic logic [7:0] frame_tx(input frame_e k, input logic [IDX_W-1:0] idx,
                                          input logic [23:0] addr, input logic [7:0] wdata);
    if (idx == '0) return frame_opcode(k);
    if ((k == FK_READ || k == FK_PROG) && idx < IDX_W'(HDR_BYTES)) begin
      case (idx[1:0])
        2'd1:    return addr[23:16];
        2'd2:    return addr[15:8];
        default: return addr[7:0];
      endcase
    end
    if (k == FK_PROG) return wdata;
    return 8'h00;
  endfunction

endpackage

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             active;
  logic             high;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sr;

  assign mosi = active & sr[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      high   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sr     <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sr     <= tx;
        cnt    <= '0;
        high   <= 1'b0;
        bitn   <= '0;
      end else if (active) begin
        if (cnt == DIV_W'(CLK_DIV - 1)) begin
          cnt <= '0;
          if (!high) begin
            sck  <= 1'b1;
            high <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sck  <= 1'b0;
            high <= 1'b0;
            sr   <= {sr[6:0], 1'b0};
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
            end
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfs_sequencer.sv
module sfs_sequencer
  import spi_flash_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  op_e         req_op,
  input  logic [15:0] req_page,
  output logic        req_ready,
  input  logic [7:0]  wr_data,
  output logic        wr_taken,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        op_done,
  output logic        op_timeout,
  output logic        cs_n,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output op_e         cur_op,
  output logic        poll_busy
);
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int PCNT_W  = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LOAD, S_SHIFT, S_END} st_e;

  st_e              state;
  frame_e           kind;
  logic [15:0]      page;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] hi_cnt;
  logic [PCNT_W-1:0] pcnt;

  assign req_ready = (state == S_IDLE);
  assign sh_start  = (state == S_LOAD);
  assign sh_tx     = frame_tx(kind, idx, page_addr(page), wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= FK_STAT;
      cur_op     <= OP_READ;
      page       <= '0;
      idx        <= '0;
      hi_cnt     <= '0;
      pcnt       <= '0;
      poll_busy  <= 1'b0;
      cs_n       <= 1'b1;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      wr_taken   <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      wr_taken   <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;

      if (!cs_n)                            hi_cnt <= '0;
      else if (hi_cnt != GAP_W'(GAP_CYC))   hi_cnt <= hi_cnt + GAP_W'(1);

      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cur_op <= req_op;
            page   <= req_page;
            kind   <= first_frame(req_op);
            pcnt   <= '0;
            state  <= S_GAP;
          end
        end
        S_GAP: begin
          if (hi_cnt >= GAP_W'(GAP_CYC)) begin
            cs_n  <= 1'b0;
            idx   <= '0;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (kind == FK_PROG && idx >= IDX_W'(HDR_BYTES)) wr_taken <= 1'b1;
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (sh_done) begin
            if (kind == FK_READ && idx >= IDX_W'(HDR_BYTES)) begin
              rd_valid <= 1'b1;
              rd_data  <= sh_rx;
            end
            if (kind == FK_STAT && idx == IDX_W'(1)) begin
              rd_valid <= 1'b1;
              rd_data  <= sh_rx;
            end
            if (kind == FK_POLL && idx == IDX_W'(1)) poll_busy <= sh_rx[0];
            if (idx == frame_len(kind) - IDX_W'(1)) begin
              cs_n  <= 1'b1;
              state <= S_END;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= S_LOAD;
            end
          end
        end
        S_END: begin
          case (kind)
            FK_WREN: begin
              kind  <= main_frame(cur_op);
              state <= S_GAP;
            end
            FK_PROG, FK_ERASE: begin
              kind  <= FK_POLL;
              pcnt  <= '0;
              state <= S_GAP;
            end
            FK_POLL: begin
              if (!poll_busy) begin
                op_done <= 1'b1;
                state   <= S_IDLE;
              end else if (pcnt == PCNT_W'(POLL_LIMIT - 1)) begin
                op_done    <= 1'b1;
                op_timeout <= 1'b1;
                state      <= S_IDLE;
              end else begin
                pcnt  <= pcnt + PCNT_W'(1);
                state <= S_GAP;
              end
            end
            default: begin
              op_done <= 1'b1;
              state   <= S_IDLE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_page,
  output logic        req_ready,
  input  logic [7:0]  wr_data,
  output logic        wr_taken,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        op_done,
  output logic        op_timeout,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_done;
  logic [7:0] sh_rx;
  op_e        cur_op;
  logic       poll_busy;

  sfs_sequencer #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (op_e'(req_op)),
    .req_page   (req_page),
    .req_ready  (req_ready),
    .wr_data    (wr_data),
    .wr_taken   (wr_taken),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .op_done    (op_done),
    .op_timeout (op_timeout),
    .cs_n       (spi_cs_n),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx),
    .cur_op     (cur_op),
    .poll_busy  (poll_busy)
  );

  sfs_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (sh_done),
    .rx    (sh_rx)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import spi_flash_seq_pkg::*;
#(
  parameter int GAP_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic req_valid,
  input logic req_ready,
  input logic op_done,
  input logic op_timeout,
  input logic rd_valid,
  input op_e  cur_op,
  input logic poll_busy
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     hi_cnt <= '0;
    else if (!cs_n)                 hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)    hi_cnt <= hi_cnt + 16'd1;
  end

  // R1
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(hi_cnt) >= 16'(GAP_CYC)));

  // R3
  cs_edge_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> !sck);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R7
  poll_idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_timeout && (cur_op == OP_PROG || cur_op == OP_ERASE)) |-> !poll_busy);

  // R8
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_timeout |-> op_done);

  // R10
  rd_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cur_op == OP_READ || cur_op == OP_STAT));

  // R11
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  done_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> req_ready);
endmodule

bind spi_flash_seq sfs_checker #(.GAP_CYC(2 * CLK_DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (spi_cs_n),
  .sck        (spi_sck),
  .mosi       (spi_mosi),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .op_done    (op_done),
  .op_timeout (op_timeout),
  .rd_valid   (rd_valid),
  .cur_op     (cur_op),
  .poll_busy  (poll_busy)
);

// File: tb/spi_flash_seq_bench.sv
`timescale 1ns/1ps
module spi_flash_seq_bench;
  localparam int CLK_DIV    = 2;
  localparam int POLL_LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_page = 16'd0;
  logic        req_ready;
  logic [7:0]  wr_data;
  logic        wr_taken;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        op_done;
  logic        op_timeout;
  logic        spi_sck;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso;

  always #2 clk = ~clk;

  spi_flash_seq #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_spi_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
    .req_ready(req_ready), .wr_data(wr_data), .wr_taken(wr_taken), .rd_data(rd_data),
    .rd_valid(rd_valid), .op_done(op_done), .op_timeout(op_timeout), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  bit summary_done = 1'b0;
  int busy_set = 0;
  logic [7:0] wbuf [0:255];

  // ---------------- flash model (single process) ----------------
  logic [7:0] mem [0:1023];
  logic [7:0] fb  [0:63][0:3];
  int         flen [0:63];
  int         nf = 0;
  int         mode_err = 0;
  int         part_err = 0;
  logic       wel = 1'b0;
  int         busy_left = 0;
  logic       miso_r = 1'b0;
  assign spi_miso = miso_r;

  function automatic logic [7:0] stat_byte(input logic w, input int b);
    return 8'h50 | {6'd0, w, (b > 0)};
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) & 8'h7F;
    forever begin
      int bits, nbytes, obit;
      logic [7:0] sh, opc, out_sr;
      logic [23:0] addr;
      @(negedge spi_cs_n);
      if (spi_sck) mode_err++;
      bits = 0; nbytes = 0; obit = 0; sh = 0; opc = 0; addr = 0;
      out_sr = 8'hA5; miso_r = 1'b1;
      if (nf < 64) for (int j = 0; j < 4; j++) fb[nf][j] = 8'h00;
      while (1) begin
        @(posedge spi_sck or negedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (spi_sck) begin
          sh = {sh[6:0], spi_mosi};
          bits++;
          if (bits == 8) begin
            bits = 0;
            if (nbytes < 4 && nf < 64) fb[nf][nbytes] = sh;
            if (nbytes == 0) begin
              opc = sh;
              out_sr = (sh == 8'h05) ? stat_byte(wel, busy_left) : 8'hA5;
            end else if ((opc == 8'h03 || opc == 8'h02) && nbytes <= 3) begin
              addr = {addr[15:0], sh};
              out_sr = (opc == 8'h03 && nbytes == 3) ? mem[addr[9:0]] : 8'hA5;
            end else if (opc == 8'h03) begin
              addr = addr + 24'd1;
              out_sr = mem[addr[9:0]];
            end else if (opc == 8'h02) begin
              if (wel) mem[addr[9:0]] = mem[addr[9:0]] & sh;
              addr = addr + 24'd1;
              out_sr = 8'hA5;
            end else if (opc == 8'h05) begin
              out_sr = stat_byte(wel, busy_left);
            end else begin
              out_sr = 8'hA5;
            end
            obit = 0;
            nbytes++;
          end
        end else if (obit < 8) begin
          miso_r = out_sr[7-obit];
          obit++;
        end
      end
      if (spi_sck) mode_err++;
      if (bits != 0) part_err++;
      if (opc == 8'h06 && nbytes == 1) wel = 1'b1;
      else if (opc == 8'hC7 && nbytes == 1 && wel) begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        busy_left = busy_set; wel = 1'b0;
      end else if (opc == 8'h02 && wel && nbytes > 4) begin
        busy_left = busy_set; wel = 1'b0;
      end else if (opc == 8'h05 && busy_left > 0) busy_left--;
      if (nf < 64) flen[nf] = nbytes;
      nf++;
    end
  end

  // ---------------- chip-select gap measurement ----------------
  int hi = 0;
  int min_gap = 1000000;
  always @(posedge clk) begin
    if (!rst_n) hi = 0;
    else if (spi_cs_n) hi = hi + 1;
    else begin
      if (hi > 0 && hi < min_gap) min_gap = hi;
      hi = 0;
    end
  end

  // ---------------- host-side monitor ----------------
  int rd_cnt = 0, wt_cnt = 0, done_cnt = 0;
  logic last_tmo = 1'b0;
  logic [7:0] rbuf [0:2047];
  assign wr_data = wbuf[wt_cnt[7:0]];
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_cnt < 2048) rbuf[rd_cnt] = rd_data;
      rd_cnt++;
    end
    if (wr_taken) wt_cnt++;
    if (op_done) begin
      done_cnt++;
      last_tmo = op_timeout;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] page);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_page = page;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low after accept", int'(req_ready), 0);
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11 single done pulse", done_cnt - d0, 1);
    chk(req_ready, "R11 ready after done", int'(req_ready), 1);
  endtask

  task automatic chk_frame(input int f, input logic [7:0] opc, input int len, input string req);
    chk(fb[f][0] == opc, req, int'(fb[f][0]), int'(opc));
    chk(flen[f] == len, req, flen[f], len);
  endtask

  task automatic t_reset;
    chk(spi_cs_n == 1'b1, "R1 cs high after reset", int'(spi_cs_n), 1);
    chk(spi_sck == 1'b0, "R1 sck low after reset", int'(spi_sck), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(!rd_valid && !op_done, "R1 no strobes after reset", int'({rd_valid, op_done}), 0);
  endtask

  task automatic t_status;
    int f0, r0;
    f0 = nf; r0 = rd_cnt;
    run_op(2'd3, 16'd0);
    chk(nf - f0 == 1, "R9 one status frame", nf - f0, 1);
    chk_frame(f0, 8'h05, 2, "R9 status frame");
    chk(rd_cnt - r0 == 1, "R9 one byte returned", rd_cnt - r0, 1);
    chk(rbuf[r0] == 8'h50, "R9 status value", int'(rbuf[r0]), 8'h50);
  endtask

  task automatic t_erase;
    int f0, r0, bad;
    f0 = nf; r0 = rd_cnt; busy_set = 3;
    run_op(2'd2, 16'h0000);
    chk(nf - f0 == 6, "R6 R7 erase frame count", nf - f0, 6);
    chk_frame(f0, 8'h06, 1, "R6 write enable frame");
    chk_frame(f0 + 1, 8'hC7, 1, "R6 erase frame");
    for (int i = 2; i < 6; i++) chk_frame(f0 + i, 8'h05, 2, "R7 poll frame");
    chk(!last_tmo, "R7 no timeout", int'(last_tmo), 0);
    chk(rd_cnt == r0, "R10 no rd_valid in erase", rd_cnt - r0, 0);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] != 8'hFF) bad++;
    chk(bad == 0, "R6 array erased", bad, 0);
  endtask

  task automatic t_program;
    int f0, r0, w0, bad;
    for (int i = 0; i < 256; i++) wbuf[i] = 8'(i * 7 + 3);
    f0 = nf; r0 = rd_cnt; w0 = wt_cnt; busy_set = 1;
    run_op(2'd1, 16'h0002);
    chk(nf - f0 == 4, "R5 R7 program frame count", nf - f0, 4);
    chk_frame(f0, 8'h06, 1, "R5 write enable frame");
    chk_frame(f0 + 1, 8'h02, 260, "R5 program frame");
    chk({fb[f0+1][1], fb[f0+1][2], fb[f0+1][3]} == 24'h000200, "R5 address bytes",
        int'({fb[f0+1][1], fb[f0+1][2], fb[f0+1][3]}), 24'h000200);
    chk_frame(f0 + 2, 8'h05, 2, "R7 poll busy");
    chk_frame(f0 + 3, 8'h05, 2, "R7 poll idle");
    chk(wt_cnt - w0 == 256, "R5 bytes taken", wt_cnt - w0, 256);
    chk(rd_cnt == r0, "R10 no rd_valid in program", rd_cnt - r0, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[512 + i] != 8'(i * 7 + 3)) bad++;
    chk(bad == 0, "R5 page contents", bad, 0);
  endtask

  task automatic t_read(input logic [15:0] page);
    int f0, r0, bad, base;
    f0 = nf; r0 = rd_cnt; base = 256 * int'(page[1:0]);
    run_op(2'd0, page);
    chk(nf - f0 == 1, "R4 one read frame", nf - f0, 1);
    chk_frame(f0, 8'h03, 260, "R4 read frame");
    chk({fb[f0][1], fb[f0][2], fb[f0][3]} == {page, 8'h00}, "R4 address bytes",
        int'({fb[f0][1], fb[f0][2], fb[f0][3]}), int'({page, 8'h00}));
    chk(rd_cnt - r0 == 256, "R4 R10 byte count", rd_cnt - r0, 256);
    bad = 0;
    for (int i = 0; i < 256; i++) if (rbuf[r0 + i] != mem[base + i]) bad++;
    chk(bad == 0, "R4 data order", bad, 0);
  endtask

  task automatic t_timeout;
    int f0;
    f0 = nf; busy_set = 100;
    run_op(2'd2, 16'h0000);
    chk(nf - f0 == 2 + POLL_LIMIT, "R8 poll count at limit", nf - f0, 2 + POLL_LIMIT);
    chk(last_tmo, "R8 timeout flagged", int'(last_tmo), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_status();
    t_erase();
    t_program();
    t_read(16'h0002);
    t_read(16'h0101);
    t_timeout();
    chk(min_gap >= 2 * CLK_DIV, "R2 select high gap", min_gap, 2 * CLK_DIV);
    chk(mode_err == 0, "R3 sck low at select edges", mode_err, 0);
    chk(part_err == 0, "R3 whole bytes per frame", part_err, 0);
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule